// File: doc/BRIEF.md
# Paged program memory address translator

This block sits between a 16-bit CPU and a 1 MB program address space. It holds a page register and uses it to steer one 16 KB window of the CPU map onto any of 64 pages. It also maps two fixed 16 KB regions onto the two highest pages and passes the bottom of the CPU map through without paging. For every valid CPU access it produces, one cycle later, a 20-bit physical address and exactly one of three selects: on-chip flash, external memory or unpaged space. A flash access also comes with the index of the flash block that holds it. An access to an external page while external memory is disabled raises an illegal flag instead of any select.

The CPU writes and reads the page register through a small register-bus port. The call and return sequence uses a separate load port, which restores a page value popped from the stack. The current page is always visible on `page_cur`, so the call path can push it before switching pages.

Top module: `page_xlate`

## Requirements
- R1: After reset the page register reads 0x00, `page_cur` is 0x00, `out_valid` is low and every select, `illegal` and `phys_addr` are 0.
- R2: A register-bus write with `reg_addr` equal to 0x30 stores bits [5:0] of `reg_wdata` into the page register. Bits [7:6] always read back as 0. `reg_rdata` returns the page for address 0x30 and 0 for any other address. Writes to any other address leave the page unchanged.
- R3: When `page_load_en` is high, bits [5:0] of `page_load_val` are stored into the page register at the next edge. A load overrides a register-bus write in the same cycle.
- R4: A CPU address in 0x8000–0xBFFF maps to {page[5:0], addr[13:0]}. The page used is the value held before any write or load made in the same cycle.
- R5: A CPU address in 0x4000–0x7FFF maps to {0x3E, addr[13:0]} with the flash select set, whatever the page register holds.
- R6: A CPU address in 0xC000–0xFFFF maps to {0x3F, addr[13:0]} with the flash select set, whatever the page register holds.
- R7: `flash_blk` is 3 for pages 0x30–0x33, 2 for 0x34–0x37, 1 for 0x38–0x3B and 0 for 0x3C–0x3F. It is 0 whenever `cs_flash` is low.
- R8: A window access with a page in 0x00–0x2F sets `cs_ext` when `expanded_mode` is high.
- R9: A window access with a page in 0x00–0x2F while `expanded_mode` is low sets `illegal` and no select. The physical address is still formed as in R4.
- R10: A CPU address below 0x4000 gives `phys_addr` = zero-extended `cpu_addr` with `cs_unpaged` set.
- R11: Results appear one clock after the access, and `out_valid` follows `cpu_valid` with one cycle of delay. A cycle without a valid access gives all outputs of the result at 0.
- R12: At most one of `cs_flash`, `cs_ext`, `cs_unpaged` and `illegal` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| expanded_mode | input | 1 | External memory enabled |
| reg_addr | input | 8 | Register-bus offset |
| reg_wr | input | 1 | Register-bus write strobe |
| reg_wdata | input | 8 | Register-bus write data |
| reg_rdata | output | 8 | Register-bus read data (combinational) |
| page_load_en | input | 1 | Restore strobe from the call/return path |
| page_load_val | input | 8 | Page value to restore |
| page_cur | output | 8 | Current page register value |
| cpu_valid | input | 1 | CPU access present |
| cpu_addr | input | 16 | CPU address |
| out_valid | output | 1 | Translation result valid |
| phys_addr | output | 20 | Physical program address |
| cs_flash | output | 1 | On-chip flash select |
| cs_ext | output | 1 | External memory select |
| cs_unpaged | output | 1 | Unpaged low-region select |
| flash_blk | output | 2 | Flash block index |
| illegal | output | 1 | External page accessed with external memory disabled |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, an 8-bit page interface with 6 implemented bits, flash starting at page 0x30 in four blocks, and the register at offset 0x30. With these values every one of the 16 flash pages can be walked through the window, so each block boundary is reached. An external page can be tried with external memory both on and off. The same-cycle cases are also within reach: a load colliding with a bus write, and a page change alongside a window access.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    // Coarse CPU-map region, taken from the top two address bits.
    typedef enum logic [1:0] {
        RGN_LOW    = 2'b00,
        RGN_FIX_LO = 2'b01,
        RGN_WIN    = 2'b10,
        RGN_FIX_HI = 2'b11
    } region_e;

endpackage

// File: rtl/pgx_page_reg.sv
module pgx_page_reg
    import pgx_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int PAGE_IMPL = 6,
    parameter int REG_AW    = 8,
    parameter int REG_OFS   = 'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PAGE_W-1:0] bus_wdata,
    output logic [PAGE_W-1:0] bus_rdata,
    input  logic              load_en,
    input  logic [PAGE_W-1:0] load_val,
    output logic [PAGE_W-1:0] page_o
);

    localparam int PAD_W = PAGE_W - PAGE_IMPL;

    typedef struct packed {
        logic [PAGE_IMPL-1:0] page;
    } preg_s;

    preg_s st_d, st_q;
    logic  hit;
    logic  unused_hi;

    assign hit       = (bus_addr == REG_AW'(REG_OFS));
    assign unused_hi = ^{bus_wdata[PAGE_W-1:PAGE_IMPL], load_val[PAGE_W-1:PAGE_IMPL]};

    always_comb begin
        st_d = st_q;
        // restore from the call/return path outranks a bus write
        if (load_en) begin
            st_d.page = load_val[PAGE_IMPL-1:0];
        end else if (bus_wr && hit) begin
            st_d.page = bus_wdata[PAGE_IMPL-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_o    = {{PAD_W{1'b0}}, st_q.page};
    assign bus_rdata = hit ? page_o : '0;

endmodule

// File: rtl/pgx_region_dec.sv
module pgx_region_dec
    import pgx_pkg::*;
#(
    parameter int CPU_AW = 16
) (
    input  logic [1:0] addr_top,
    output region_e    region
);

    always_comb begin
        unique case (addr_top)
            2'b00:   region = RGN_LOW;
            2'b01:   region = RGN_FIX_LO;
            2'b10:   region = RGN_WIN;
            default: region = RGN_FIX_HI;
        endcase
    end

endmodule

// File: rtl/pgx_flash_map.sv
module pgx_flash_map #(
    parameter int PAGE_IMPL    = 6,
    parameter int FLASH_BASE   = 'h30,
    parameter int FLASH_BLOCKS = 4
) (
    input  logic [PAGE_IMPL-1:0]            page,
    output logic                            is_flash,
    output logic [$clog2(FLASH_BLOCKS)-1:0] blk
);

    localparam int NUM_PAGES   = 1 << PAGE_IMPL;
    localparam int FLASH_PAGES = NUM_PAGES - FLASH_BASE;
    localparam int PPB         = FLASH_PAGES / FLASH_BLOCKS;
    localparam int BLK_W       = $clog2(FLASH_BLOCKS);

    logic [FLASH_BLOCKS-1:0] grp_hit;

    // one range comparator per group of pages; the lowest group is the
    // highest-numbered block
    for (genvar g = 0; g < FLASH_BLOCKS; g++) begin : g_grp
        localparam int LO = FLASH_BASE + g * PPB;
        localparam int HI = LO + PPB;
        assign grp_hit[g] = (int'(page) >= LO) && (int'(page) < HI);
    end

    always_comb begin
        blk = '0;
        for (int i = 0; i < FLASH_BLOCKS; i++) begin
            if (grp_hit[i]) begin
                blk = BLK_W'(FLASH_BLOCKS - 1 - i);
            end
        end
    end

    assign is_flash = |grp_hit;

endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import pgx_pkg::*;
#(
    parameter int CPU_AW       = 16,
    parameter int PAGE_W       = 8,
    parameter int PAGE_IMPL    = 6,
    parameter int REG_AW       = 8,
    parameter int REG_OFS      = 'h30,
    parameter int FLASH_BASE   = 'h30,
    parameter int FLASH_BLOCKS = 4,
    parameter int FIX_LO_PAGE  = 'h3E,
    parameter int FIX_HI_PAGE  = 'h3F,
    localparam int WIN_AW      = CPU_AW - 2,
    localparam int PHYS_W      = PAGE_IMPL + WIN_AW,
    localparam int BLK_W       = $clog2(FLASH_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expanded_mode,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [PAGE_W-1:0] reg_wdata,
    output logic [PAGE_W-1:0] reg_rdata,
    input  logic              page_load_en,
    input  logic [PAGE_W-1:0] page_load_val,
    output logic [PAGE_W-1:0] page_cur,
    input  logic              cpu_valid,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic              out_valid,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              cs_flash,
    output logic              cs_ext,
    output logic              cs_unpaged,
    output logic [BLK_W-1:0]  flash_blk,
    output logic              illegal
);

    typedef struct packed {
        logic              valid;
        logic [PHYS_W-1:0] phys;
        logic              fl;
        logic              ext;
        logic              unp;
        logic              ill;
        logic [BLK_W-1:0]  blk;
    } xres_s;

    region_e              region;
    logic [PAGE_IMPL-1:0] eff_page;
    logic                 map_flash;
    logic [BLK_W-1:0]     map_blk;
    xres_s                x_d, x_q;

    pgx_page_reg #(
        .PAGE_W    (PAGE_W),
        .PAGE_IMPL (PAGE_IMPL),
        .REG_AW    (REG_AW),
        .REG_OFS   (REG_OFS)
    ) u_preg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (reg_addr),
        .bus_wr    (reg_wr),
        .bus_wdata (reg_wdata),
        .bus_rdata (reg_rdata),
        .load_en   (page_load_en),
        .load_val  (page_load_val),
        .page_o    (page_cur)
    );

    pgx_region_dec #(
        .CPU_AW   (CPU_AW)
    ) u_rdec (
        .addr_top (cpu_addr[CPU_AW-1 -: 2]),
        .region   (region)
    );

    // fixed regions are hard-wired to their alias pages
    always_comb begin
        unique case (region)
            RGN_FIX_LO: eff_page = PAGE_IMPL'(FIX_LO_PAGE);
            RGN_FIX_HI: eff_page = PAGE_IMPL'(FIX_HI_PAGE);
            default:    eff_page = page_cur[PAGE_IMPL-1:0];
        endcase
    end

    pgx_flash_map #(
        .PAGE_IMPL    (PAGE_IMPL),
        .FLASH_BASE   (FLASH_BASE),
        .FLASH_BLOCKS (FLASH_BLOCKS)
    ) u_fmap (
        .page     (eff_page),
        .is_flash (map_flash),
        .blk      (map_blk)
    );

    always_comb begin
        x_d       = '0;
        x_d.valid = cpu_valid;
        if (cpu_valid) begin
            if (region == RGN_LOW) begin
                x_d.phys = PHYS_W'(cpu_addr);
                x_d.unp  = 1'b1;
            end else begin
                x_d.phys = {eff_page, cpu_addr[WIN_AW-1:0]};
                if (map_flash) begin
                    x_d.fl  = 1'b1;
                    x_d.blk = map_blk;
                end else if (expanded_mode) begin
                    x_d.ext = 1'b1;
                end else begin
                    x_d.ill = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
        end else begin
            x_q <= x_d;
        end
    end

    assign out_valid  = x_q.valid;
    assign phys_addr  = x_q.phys;
    assign cs_flash   = x_q.fl;
    assign cs_ext     = x_q.ext;
    assign cs_unpaged = x_q.unp;
    assign flash_blk  = x_q.blk;
    assign illegal    = x_q.ill;

endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
    parameter int PAGE_W      = 8,
    parameter int PAGE_IMPL   = 6,
    parameter int REG_AW      = 8,
    parameter int REG_OFS     = 'h30,
    parameter int FLASH_BASE  = 'h30,
    parameter int FIX_LO_PAGE = 'h3E,
    parameter int FIX_HI_PAGE = 'h3F
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 expanded_mode,
    input logic [REG_AW-1:0]    reg_addr,
    input logic                 reg_wr,
    input logic [PAGE_IMPL-1:0] wdata_lo,
    input logic                 page_load_en,
    input logic [PAGE_IMPL-1:0] load_lo,
    input logic [PAGE_W-1:0]    page_cur,
    input logic                 cpu_valid,
    input logic [1:0]           cpu_top,
    input logic                 out_valid,
    input logic [PAGE_IMPL-1:0] phys_page,
    input logic                 cs_flash,
    input logic                 cs_ext,
    input logic                 cs_unpaged,
    input logic                 illegal
);

    assert_one_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_flash, cs_ext, cs_unpaged, illegal}));

    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(cpu_valid)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(cs_flash || cs_ext || cs_unpaged || illegal));

    assert_bus_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && reg_wr && !page_load_en && (reg_addr == REG_AW'(REG_OFS)))
        |-> (page_cur == PAGE_W'($past(wdata_lo))));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && page_load_en) |-> (page_cur == PAGE_W'($past(load_lo))));

    assert_fix_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cpu_valid && (cpu_top == 2'b01))
        |-> (cs_flash && (phys_page == PAGE_IMPL'(FIX_LO_PAGE))));

    assert_fix_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cpu_valid && (cpu_top == 2'b11))
        |-> (cs_flash && (phys_page == PAGE_IMPL'(FIX_HI_PAGE))));

    assert_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cpu_valid && (cpu_top == 2'b10) && !expanded_mode &&
              (page_cur[PAGE_IMPL-1:0] < PAGE_IMPL'(FLASH_BASE)))
        |-> (illegal && !cs_ext));

endmodule

bind page_xlate page_xlate_chk #(
    .PAGE_W      (PAGE_W),
    .PAGE_IMPL   (PAGE_IMPL),
    .REG_AW      (REG_AW),
    .REG_OFS     (REG_OFS),
    .FLASH_BASE  (FLASH_BASE),
    .FIX_LO_PAGE (FIX_LO_PAGE),
    .FIX_HI_PAGE (FIX_HI_PAGE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .expanded_mode (expanded_mode),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .wdata_lo      (reg_wdata[PAGE_IMPL-1:0]),
    .page_load_en  (page_load_en),
    .load_lo       (page_load_val[PAGE_IMPL-1:0]),
    .page_cur      (page_cur),
    .cpu_valid     (cpu_valid),
    .cpu_top       (cpu_addr[CPU_AW-1 -: 2]),
    .out_valid     (out_valid),
    .phys_page     (phys_addr[PHYS_W-1 -: PAGE_IMPL]),
    .cs_flash      (cs_flash),
    .cs_ext        (cs_ext),
    .cs_unpaged    (cs_unpaged),
    .illegal       (illegal)
);

// File: tb/page_xlate_test.sv
`timescale 1ns/1ps
module page_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        expanded_mode = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        page_load_en = 1'b0;
    logic [7:0]  page_load_val = '0;
    logic [7:0]  page_cur;
    logic        cpu_valid = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        out_valid;
    logic [19:0] phys_addr;
    logic        cs_flash, cs_ext, cs_unpaged, illegal;
    logic [1:0]  flash_blk;

    always #5 clk = ~clk;

    page_xlate uut (
        .clk(clk), .rst_n(rst_n), .expanded_mode(expanded_mode),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .page_load_en(page_load_en),
        .page_load_val(page_load_val), .page_cur(page_cur),
        .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .out_valid(out_valid),
        .phys_addr(phys_addr), .cs_flash(cs_flash), .cs_ext(cs_ext),
        .cs_unpaged(cs_unpaged), .flash_blk(flash_blk), .illegal(illegal)
    );

    typedef struct packed {
        logic        v;
        logic [19:0] pa;
        logic        fl;
        logic        ex;
        logic        un;
        logic        il;
        logic [1:0]  blk;
        logic [7:0]  pg;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    logic [5:0] mpage = '0;
    bit    done = 1'b0;

    function automatic exp_t model(logic v, logic [15:0] a, logic [5:0] pg,
                                   logic ex, logic [5:0] nxt);
        exp_t r;
        logic [5:0] eff;
        r = '0;
        r.pg = {2'b00, nxt};
        if (!v) return r;
        r.v = 1'b1;
        if (a < 16'h4000) begin
            r.pa = {4'h0, a};
            r.un = 1'b1;
            return r;
        end
        if (a < 16'h8000)      eff = 6'h3E;
        else if (a < 16'hC000) eff = pg;
        else                   eff = 6'h3F;
        r.pa = {eff, a[13:0]};
        if (eff >= 6'h30) begin
            r.fl = 1'b1;
            if (eff < 6'h34)      r.blk = 2'd3;
            else if (eff < 6'h38) r.blk = 2'd2;
            else if (eff < 6'h3C) r.blk = 2'd1;
            else                  r.blk = 2'd0;
        end else if (ex) begin
            r.ex = 1'b1;
        end else begin
            r.il = 1'b1;
        end
        return r;
    endfunction

    // drive one cycle of stimulus and queue the expected result
    task automatic step(input string tag, input logic v, input logic [15:0] a,
                        input logic ex, input logic ld, input logic [7:0] lv,
                        input logic wr, input logic [7:0] wa, input logic [7:0] wd);
        logic [5:0] nxt;
        @(negedge clk);
        cpu_valid = v; cpu_addr = a; expanded_mode = ex;
        page_load_en = ld; page_load_val = lv;
        reg_wr = wr; reg_addr = wa; reg_wdata = wd;
        nxt = mpage;
        if (ld)                      nxt = lv[5:0];
        else if (wr && wa == 8'h30)  nxt = wd[5:0];
        exp_q.push_back(model(v, a, mpage, ex, nxt));
        tag_q.push_back(tag);
        mpage = nxt;
    endtask

    task automatic readreg(input string tag, input logic [7:0] a, input logic [7:0] expv);
        step(tag, 1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 1'b0, a, 8'h0);
        #1;
        n_chk++;
        if (reg_rdata !== expv) begin
            n_bad++;
            $display("FAIL %s reg_rdata addr=%h got=%h exp=%h", tag, a, reg_rdata, expv);
        end
    endtask

    // scoreboard monitor: results are due one edge after they were queued
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e, g;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            g = '{out_valid, phys_addr, cs_flash, cs_ext, cs_unpaged, illegal,
                  flash_blk, page_cur};
            n_chk++;
            if (g !== e) begin
                n_bad++;
                $display("FAIL %s got v=%b pa=%h fl=%b ex=%b un=%b il=%b blk=%0d pg=%h exp v=%b pa=%h fl=%b ex=%b un=%b il=%b blk=%0d pg=%h",
                         t, g.v, g.pa, g.fl, g.ex, g.un, g.il, g.blk, g.pg,
                         e.v, e.pa, e.fl, e.ex, e.un, e.il, e.blk, e.pg);
            end
            n_chk++;
            if ($countones({cs_flash, cs_ext, cs_unpaged, illegal}) > 1) begin
                n_bad++;
                $display("FAIL R12 selects=%b exp at most one high",
                         {cs_flash, cs_ext, cs_unpaged, illegal});
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        n_chk++;
        if ({out_valid, phys_addr, cs_flash, cs_ext, cs_unpaged, illegal, flash_blk, page_cur} !== '0) begin
            n_bad++;
            $display("FAIL R1 reset outputs got=%h exp=0",
                     {out_valid, phys_addr, cs_flash, cs_ext, cs_unpaged, illegal, flash_blk, page_cur});
        end
        readreg("R1", 8'h30, 8'h00);

        // R2: write, upper bits dropped, other offsets ignored
        step("R2", 1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 1'b1, 8'h30, 8'hFF);
        readreg("R2", 8'h30, 8'h3F);
        step("R2", 1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 1'b1, 8'h31, 8'h05);
        readreg("R2", 8'h31, 8'h00);
        readreg("R2", 8'h30, 8'h3F);

        // R3: load beats same-cycle bus write
        step("R3", 1'b0, 16'h0, 1'b0, 1'b1, 8'hEA, 1'b1, 8'h30, 8'h11);
        readreg("R3", 8'h30, 8'h2A);

        // R4 + R7: walk every flash page through the window
        for (int p = 'h30; p <= 'h3F; p++) begin
            step("R3", 1'b0, 16'h0, 1'b0, 1'b1, 8'(p), 1'b0, 8'h0, 8'h0);
            step("R7", 1'b1, 16'h8000 + 16'(p * 37), 1'b0, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
            step("R4", 1'b1, 16'hBFFF, 1'b0, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
        end

        // R4: window access in the same cycle as a page write uses the old page
        step("R4", 1'b1, 16'h9ABC, 1'b1, 1'b0, 8'h0, 1'b1, 8'h30, 8'h05);
        step("R4", 1'b1, 16'h9ABC, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);

        // R5 / R6: fixed regions ignore the page register (page now 0x05)
        step("R5", 1'b1, 16'h4000, 1'b0, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
        step("R5", 1'b1, 16'h7FFF, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
        step("R6", 1'b1, 16'hC000, 1'b0, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
        step("R6", 1'b1, 16'hFFFE, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);

        // R8 / R9: external pages with and without expanded mode
        step("R8", 1'b1, 16'h8123, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
        step("R9", 1'b1, 16'h8123, 1'b0, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
        step("R3", 1'b0, 16'h0, 1'b0, 1'b1, 8'h2F, 1'b0, 8'h0, 8'h0);
        step("R9", 1'b1, 16'hA000, 1'b0, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
        step("R8", 1'b1, 16'hA000, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);

        // R10: unpaged low region
        step("R10", 1'b1, 16'h0000, 1'b0, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
        step("R10", 1'b1, 16'h3FFF, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);

        // R11: idle gaps between accesses
        step("R11", 1'b0, 16'hC123, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
        step("R11", 1'b1, 16'hC123, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);
        step("R11", 1'b0, 16'h8000, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0, 8'h0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule